// File: doc/BRIEF.md
# Fused Dependent-Pair ALU

This execution unit takes two dependent operations, a head and a tail, and runs them as one operation. The head combines the first two source operands. Its value feeds the tail inside the unit and never reaches the forwarding network. The tail combines that value with the third operand. Depending on the tail kind, the tail is a second ALU operation, an address computation for a memory access, or a conditional branch that tests the head's flags. The branch outcome and the effective address come out in the same registered cycle as the head's work.

A fused pair reads at most two distinct registers. The third input is normally an immediate. When the scheduler marks a pair as writing two destinations, the head value is also flagged for a second writeback. With the fuse indication low, the unit runs the head operation alone and leaves every tail output deasserted. Every output is registered with one cycle of latency.

Top module: `fused_alu`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is zero after that edge.
- R2: Opcode encoding: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right. Shifts use the low log2(W) bits of the second operand. In single mode, `result` is `src_a op src_b`.
- R3: `flags` bit 0 is zero, bit 1 is sign (MSB of the result), bit 2 is carry, bit 3 is overflow. Carry is the carry-out for add, the borrow (first operand unsigned-less-than second) for subtract, and 0 otherwise. Overflow is signed overflow for add and subtract, and 0 otherwise. `flags` reports the operation whose value drives `result`.
- R4: With `fuse_en` high and tail kind 0 or 3 (ALU), `result` = (`src_a` head_op `src_b`) tail_op `src_c`.
- R5: With tail kind 1 (branch), `result` and `flags` are the head's, `branch_valid` is 1, and `taken` evaluates `cond_sel` on the head flags. The condition codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 S, 5 !S, 6 V, 7 !V, 8 S^V, 9 !(S^V), 10 Z|(S^V), 11 !(Z|(S^V)), 12 always, 13–15 never.
- R6: With tail kind 2 (address), `result` = head value + `src_c`, the flags come from that add, and `addr_valid` is 1.
- R7: `head_result` always carries the head value. `head_wb_valid` is 1 only for a fused pair issued with `head_wb_req` high.
- R8: With `fuse_en` low, `tail_valid`, `branch_valid`, `addr_valid`, `taken` and `head_wb_valid` are 0, and `result` equals the head value.
- R9: An operation issued with `in_valid` high appears on the outputs after exactly one rising edge. An edge with `in_valid` low clears `out_valid` and leaves `result`, `head_result` and `flags` unchanged.
- R10: Opcodes 7 to 15 produce a result of 0, with only the zero flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| fuse_en | input | 1 | Execute head and tail as a pair |
| head_wb_req | input | 1 | Pair also writes the head's destination |
| head_op | input | 4 | Head opcode |
| tail_kind | input | 2 | 0/3 ALU, 1 branch, 2 address |
| tail_op | input | 4 | Tail opcode for an ALU tail |
| cond_sel | input | 4 | Branch condition code |
| src_a | input | W | First source |
| src_b | input | W | Second source |
| src_c | input | W | Third source (usually immediate) |
| out_valid | output | 1 | Registered result valid |
| tail_valid | output | 1 | A fused tail was executed |
| branch_valid | output | 1 | Tail was a branch |
| addr_valid | output | 1 | `result` is an effective address |
| taken | output | 1 | Branch outcome |
| head_wb_valid | output | 1 | `head_result` must be written back |
| result | output | W | Primary result |
| head_result | output | W | Head value |
| flags | output | 4 | {V,C,S,Z} of the primary operation |

## Verification
All state is the single output register stage, so a wrong internal value shows up on the ports at the first edge after the faulty operation is issued and persists until the next valid issue. Wrong operand routing between head and tail shows as a mismatch between `result` and the head value on `head_result`. A mis-decoded condition shows as a wrong `taken` on that same cycle. The sweeps run a narrow 8-bit configuration over every opcode pair, every condition code and operand values that include the sign, carry and zero boundaries.

// File: rtl/fused_alu_pkg.sv
// Shared encodings for the fused dependent-pair ALU.
// Assumes 4-bit opcodes and 2-bit tail kinds, as seen at the top-level ports.
package fused_alu_pkg;
    localparam logic [3:0] OP_ADD = 4'd0;
    localparam logic [3:0] OP_SUB = 4'd1;
    localparam logic [3:0] OP_AND = 4'd2;
    localparam logic [3:0] OP_OR  = 4'd3;
    localparam logic [3:0] OP_XOR = 4'd4;
    localparam logic [3:0] OP_SHL = 4'd5;
    localparam logic [3:0] OP_SHR = 4'd6;

    localparam logic [1:0] TK_BRANCH = 2'd1;
    localparam logic [1:0] TK_ADDR   = 2'd2;

    typedef struct packed {
        logic v;
        logic c;
        logic s;
        logic z;
    } flags_t;
endpackage

// File: rtl/alu_core.sv
// Single-cycle combinational ALU stage with flag generation.
// Assumes W >= 2. Opcodes outside the defined set yield zero.
module alu_core
    import fused_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] r,
    output flags_t       f
);
    localparam int SHW = $clog2(W);

    logic [W:0] wide;
    logic       cy;
    logic       ov;

    // Compute the operation result together with its carry and overflow.
    always_comb begin
        wide = '0;
        r    = '0;
        cy   = 1'b0;
        ov   = 1'b0;
        case (op)
            OP_ADD: begin
                wide = {1'b0, x} + {1'b0, y};
                r    = wide[W-1:0];
                cy   = wide[W];
                ov   = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
            end
            OP_SUB: begin
                wide = {1'b0, x} - {1'b0, y};
                r    = wide[W-1:0];
                cy   = wide[W];
                ov   = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
            end
            OP_AND: r = x & y;
            OP_OR:  r = x | y;
            OP_XOR: r = x ^ y;
            OP_SHL: r = x << y[SHW-1:0];
            OP_SHR: r = x >> y[SHW-1:0];
            default: r = '0;
        endcase
        f.z = (r == '0);
        f.s = r[W-1];
        f.c = cy;
        f.v = ov;
    end
endmodule

// File: rtl/cond_eval.sv
// Evaluates a 4-bit branch condition code against a set of flags.
// Assumes codes 13 to 15 mean "never".
module cond_eval
    import fused_alu_pkg::*;
(
    input  logic [3:0] code,
    input  flags_t     fl,
    output logic       take
);
    logic lt;

    // Decode the condition code into a taken/not-taken decision.
    always_comb begin
        lt = fl.s ^ fl.v;
        case (code)
            4'd0:    take = fl.z;
            4'd1:    take = !fl.z;
            4'd2:    take = fl.c;
            4'd3:    take = !fl.c;
            4'd4:    take = fl.s;
            4'd5:    take = !fl.s;
            4'd6:    take = fl.v;
            4'd7:    take = !fl.v;
            4'd8:    take = lt;
            4'd9:    take = !lt;
            4'd10:   take = fl.z | lt;
            4'd11:   take = !(fl.z | lt);
            4'd12:   take = 1'b1;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/fused_alu.sv
// Fused dependent-pair execution unit: head = a op b, tail consumes the head
// value with c, all within one registered cycle.
// Assumes the scheduler only fuses single-cycle ALU heads; the head value
// stays internal unless head_wb_req marks a second destination.
module fused_alu
    import fused_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         fuse_en,
    input  logic         head_wb_req,
    input  logic [3:0]   head_op,
    input  logic [1:0]   tail_kind,
    input  logic [3:0]   tail_op,
    input  logic [3:0]   cond_sel,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic [W-1:0] src_c,
    output logic         out_valid,
    output logic         tail_valid,
    output logic         branch_valid,
    output logic         addr_valid,
    output logic         taken,
    output logic         head_wb_valid,
    output logic [W-1:0] result,
    output logic [W-1:0] head_result,
    output logic [3:0]   flags
);
    logic [W-1:0] h_val, t_val, p_val;
    flags_t       h_fl, t_fl, p_fl;
    logic [3:0]   t_op;
    logic         is_br, is_addr, br_take;

    alu_core #(.W(W)) u_head (.op(head_op), .x(src_a), .y(src_b), .r(h_val), .f(h_fl));

    // Address tails always add; ALU tails use their own opcode.
    always_comb t_op = (tail_kind == TK_ADDR) ? OP_ADD : tail_op;

    alu_core #(.W(W)) u_tail (.op(t_op), .x(h_val), .y(src_c), .r(t_val), .f(t_fl));

    cond_eval u_cond (.code(cond_sel), .fl(h_fl), .take(br_take));

    // Choose the primary result and its flags for the current mode.
    always_comb begin
        is_br   = fuse_en && (tail_kind == TK_BRANCH);
        is_addr = fuse_en && (tail_kind == TK_ADDR);
        if (fuse_en && !is_br) begin
            p_val = t_val;
            p_fl  = t_fl;
        end else begin
            p_val = h_val;
            p_fl  = h_fl;
        end
    end

    // Output register stage: control clears when idle, data holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            tail_valid    <= 1'b0;
            branch_valid  <= 1'b0;
            addr_valid    <= 1'b0;
            taken         <= 1'b0;
            head_wb_valid <= 1'b0;
            result        <= '0;
            head_result   <= '0;
            flags         <= '0;
        end else begin
            out_valid     <= in_valid;
            tail_valid    <= in_valid && fuse_en;
            branch_valid  <= in_valid && is_br;
            addr_valid    <= in_valid && is_addr;
            taken         <= in_valid && is_br && br_take;
            head_wb_valid <= in_valid && fuse_en && head_wb_req;
            if (in_valid) begin
                result      <= p_val;
                head_result <= h_val;
                flags       <= p_fl;
            end
        end
    end

    // R9: a valid issue shows up after exactly one edge.
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid) |-> out_valid);

    // R9: an idle edge leaves the data outputs unchanged.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(in_valid) |-> $stable(result) && $stable(head_result) && !out_valid);

    // R8: without a tail, the primary result is the head value.
    a_r8_single_head: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !tail_valid |-> result == head_result && !taken && !head_wb_valid);

    // R5 and R6: a tail is never both a branch and an address.
    a_r5_kind_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({branch_valid, addr_valid}));

    // R6: the effective address is the head value plus the third source.
    a_r6_addr_sum: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> result == W'(head_result + $past(src_c)));

    // R7: the head writeback is only flagged for a fused pair.
    a_r7_wb_fused: assert property (@(posedge clk) disable iff (!rst_n)
        head_wb_valid |-> tail_valid && out_valid);
endmodule

// File: tb/fused_alu_test.sv
// Self-checking sweeps of an 8-bit configuration of the fused ALU.
module fused_alu_test;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, fuse_en = 1'b0, head_wb_req = 1'b0;
    logic [3:0] head_op = '0, tail_op = '0, cond_sel = '0;
    logic [1:0] tail_kind = '0;
    logic [W-1:0] src_a = '0, src_b = '0, src_c = '0;
    logic out_valid, tail_valid, branch_valid, addr_valid, taken, head_wb_valid;
    logic [W-1:0] result, head_result;
    logic [3:0] flags;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fused_alu #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fuse_en(fuse_en),
        .head_wb_req(head_wb_req), .head_op(head_op), .tail_kind(tail_kind),
        .tail_op(tail_op), .cond_sel(cond_sel), .src_a(src_a), .src_b(src_b),
        .src_c(src_c), .out_valid(out_valid), .tail_valid(tail_valid),
        .branch_valid(branch_valid), .addr_valid(addr_valid), .taken(taken),
        .head_wb_valid(head_wb_valid), .result(result), .head_result(head_result),
        .flags(flags)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference ALU: returns {V,C,S,Z,result}.
    function automatic logic [11:0] ref_op(input logic [3:0] op, input logic [7:0] x, input logic [7:0] y);
        int r = 0;
        bit c = 0, v = 0;
        case (op)
            4'd0: begin r = int'(x) + int'(y); c = r > 255; r = r & 255;
                  v = (x[7] == y[7]) && (r[7] != x[7]); end
            4'd1: begin c = x < y; r = (int'(x) - int'(y)) & 255;
                  v = (x[7] != y[7]) && (r[7] != x[7]); end
            4'd2: r = x & y;
            4'd3: r = x | y;
            4'd4: r = x ^ y;
            4'd5: r = (int'(x) << y[2:0]) & 255;
            4'd6: r = int'(x) >> y[2:0];
            default: r = 0;
        endcase
        return {v, c, r[7], r == 0, r[7:0]};
    endfunction

    function automatic bit ref_cond(input logic [3:0] cc, input logic [3:0] f);
        bit z = f[0], s = f[1], c = f[2], v = f[3];
        case (cc)
            0: return z;        1: return !z;
            2: return c;        3: return !c;
            4: return s;        5: return !s;
            6: return v;        7: return !v;
            8: return s ^ v;    9: return !(s ^ v);
            10: return z | (s ^ v);
            11: return !(z | (s ^ v));
            12: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Issue one operation and check every output one edge later.
    task automatic run_op(input bit fz, input bit wb, input logic [3:0] hop, input logic [1:0] kd,
                          input logic [3:0] top, input logic [3:0] cc,
                          input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        logic [11:0] h, t;
        logic [7:0] exp_r;
        logic [3:0] exp_f;
        logic [5:0] exp_ctl;
        string rtag;
        in_valid = 1'b1; fuse_en = fz; head_wb_req = wb; head_op = hop;
        tail_kind = kd; tail_op = top; cond_sel = cc; src_a = a; src_b = b; src_c = c;
        h = ref_op(hop, a, b);
        if (!fz) begin
            t = h; rtag = (hop > 6) ? "R10" : "R2";
            exp_ctl = 6'b100000;
        end else if (kd == 2'd1) begin
            t = h; rtag = "R5";
            exp_ctl = {4'b1110, ref_cond(cc, h[11:8]), wb};
        end else if (kd == 2'd2) begin
            t = ref_op(4'd0, h[7:0], c); rtag = "R6";
            exp_ctl = {4'b1101, 1'b0, wb};
        end else begin
            t = ref_op(top, h[7:0], c); rtag = "R4";
            exp_ctl = {4'b1100, 1'b0, wb};
        end
        exp_r = t[7:0]; exp_f = t[11:8];
        @(posedge clk); #1;
        chk(result == exp_r, rtag, result, exp_r);
        chk(flags == exp_f, "R3", flags, exp_f);
        chk(head_result == h[7:0], "R7", head_result, h[7:0]);
        chk({out_valid, tail_valid, branch_valid, addr_valid, taken, head_wb_valid} == exp_ctl,
            fz ? ((kd == 2'd1) ? "R5" : "R7") : "R8",
            {out_valid, tail_valid, branch_valid, addr_valid, taken, head_wb_valid}, exp_ctl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] keep_r, keep_h;
        // R1: reset clears every output.
        repeat (2) @(posedge clk);
        #1;
        chk({out_valid, tail_valid, branch_valid, addr_valid, taken, head_wb_valid, result, head_result, flags} == '0,
            "R1", result, 0);
        rst_n = 1'b1;

        // R2, R3, R8, R10: single-mode sweep over all opcodes.
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    run_op(1'b0, 1'b1, 4'(op), 2'd0, 4'd0, 4'd0, 8'(i * 17), 8'(j * 17 + i), 8'd0);

        // R4, R7: every head/tail ALU opcode pair.
        for (int hop = 0; hop < 7; hop++)
            for (int top = 0; top < 7; top++)
                for (int i = 0; i < 6; i++)
                    for (int j = 0; j < 6; j++)
                        for (int k = 0; k < 6; k++)
                            run_op(1'b1, 1'((i + k) % 2), 4'(hop), (hop == 3) ? 2'd3 : 2'd0, 4'(top), 4'd0,
                                   8'(i * 51), 8'(j * 51 + 1), 8'(k * 51 + 2));

        // R5: branch tails, every condition code on add and subtract heads.
        for (int hop = 0; hop < 2; hop++)
            for (int cc = 0; cc < 16; cc++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++)
                        run_op(1'b1, 1'b0, 4'(hop), 2'd1, 4'd0, 4'(cc), 8'(i * 37 + 1), 8'(j * 37), 8'd0);

        // R6: address tails.
        for (int hop = 0; hop < 7; hop++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int k = 0; k < 6; k++)
                        run_op(1'b1, 1'b1, 4'(hop), 2'd2, 4'd4, 4'd0, 8'(i * 51), 8'(j * 51), 8'(k * 51 + 3));

        // R9: latency of one edge, and hold while idle.
        run_op(1'b0, 1'b0, 4'd0, 2'd0, 4'd0, 4'd0, 8'd20, 8'd22, 8'd0);
        keep_r = result; keep_h = head_result;
        src_a = 8'd99; src_b = 8'd1;
        #1;
        chk(result == 8'd42, "R9", result, 42);
        in_valid = 1'b0;
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R9", out_valid, 0);
        chk(result == keep_r && head_result == keep_h, "R9", result, keep_r);

        // R1: reset in the middle of operation.
        run_op(1'b1, 1'b1, 4'd0, 2'd1, 4'd0, 4'd12, 8'd1, 8'd2, 8'd0);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk({out_valid, taken, head_wb_valid, result, flags} == '0, "R1", result, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule